// File: doc/BRIEF.md
# Wallace-Tree 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their full 8-bit product with no clock and no storage. Sixteen AND gates form one partial-product bit per operand-bit pair. Each bit carries the weight of the sum of its two bit indices. The columns of equal weight are then compressed in two carry-save stages of full and half adders. A sum stays in its own column and a carry moves one column up. After the second stage no column holds more than two bits. A ripple-carry adder over the upper seven bit positions merges the two remaining rows into the product.

The block sits on a datapath wherever a small product must be ready within the same evaluation as its operands. Its depth is two compressor levels plus one short carry chain, so it is shallower than a row-by-row array of ripple adders.

Top module: `wallace_mul4`

## Requirements
- R1: For every one of the 256 operand pairs, `z` equals the unsigned product of `x` and `y`.
- R2: `z[0]` always equals `x[0] & y[0]`; no adder lies on the path to bit 0.
- R3: The largest operands, 15 and 15, give 225 (8'hE1). The product always fits in 8 bits, so the carry out of the final adder's top bit (bit 7) is always zero.
- R4: If either operand is zero, `z` is zero. This includes the all-zero inputs present at time zero.
- R5: If one operand is 1, `z[3:0]` equals the other operand and `z[7:4]` is zero.
- R6: If `x` is 2^k (k from 0 to 3), `z` equals `y` shifted left by k places.
- R7: Swapping `x` and `y` never changes `z`.
- R8: The block is purely combinational. A new operand pair shows its product on `z` in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 4 | Multiplicand, unsigned |
| y | input | 4 | Multiplier, unsigned |
| z | output | 8 | Unsigned product x*y |

## Verification
Every result is due zero cycles after its stimulus, because the block has no registers. The bench changes the operands on a falling clock edge and compares `z` with an integer reference one time unit after the next rising edge. That leaves half a period for the logic to settle, with no edge ordering involved. For R8 the bench also samples one time unit after a change made between edges, with no rising edge in between. This shows the product does not wait on any clock.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int OP_W   = 4;
  localparam int PROD_W = 2 * OP_W;
  localparam int SUM_W  = PROD_W + 2;

  typedef logic [OP_W-1:0][OP_W-1:0] pp_mat_t;
  typedef logic [PROD_W-1:0]         row_t;
endpackage

// File: rtl/wt_fa.sv
module wt_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (ci & (a ^ b));
  end
endmodule

// File: rtl/wt_ha.sv
module wt_ha (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b;
    co = a & b;
  end
endmodule

// File: rtl/wt_ppgen.sv
module wt_ppgen
  import wt_pkg::*;
(
  input  logic [OP_W-1:0] x,
  input  logic [OP_W-1:0] y,
  output pp_mat_t         pp
);
  for (genvar i = 0; i < OP_W; i++) begin : g_row
    for (genvar j = 0; j < OP_W; j++) begin : g_col
      assign pp[i][j] = x[i] & y[j];
    end
  end
endmodule

// File: rtl/wt_stage1.sv
module wt_stage1
  import wt_pkg::*;
(
  input  pp_mat_t pp,
  output row_t    r0,
  output row_t    r1,
  output row_t    r2
);
  logic s2, c2, s3, c3, s4, c4;

  wt_fa u_fa_c2 (.a(pp[0][2]), .b(pp[1][1]), .ci(pp[2][0]), .s(s2), .co(c2));
  wt_fa u_fa_c3 (.a(pp[0][3]), .b(pp[1][2]), .ci(pp[2][1]), .s(s3), .co(c3));
  wt_fa u_fa_c4 (.a(pp[1][3]), .b(pp[2][2]), .ci(pp[3][1]), .s(s4), .co(c4));

  always_comb begin
    r0 = '0;
    r1 = '0;
    r2 = '0;
    r0[0] = pp[0][0];
    r0[1] = pp[0][1];
    r1[1] = pp[1][0];
    r0[2] = s2;
    r0[3] = s3;
    r1[3] = pp[3][0];
    r2[3] = c2;
    r0[4] = s4;
    r1[4] = c3;
    r0[5] = pp[2][3];
    r1[5] = pp[3][2];
    r2[5] = c4;
    r0[6] = pp[3][3];
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < OP_W; i++)
      for (int j = 0; j < OP_W; j++)
        acc += int'(pp[i][j]) << (i + j);
    // R1: the three carry-save rows keep the weighted value of all partial products
    p_stage1_value_r1: assert (int'(r0) + int'(r1) + int'(r2) == acc)
      else $error("stage1 rows lost weight");
  end
endmodule

// File: rtl/wt_stage2.sv
module wt_stage2
  import wt_pkg::*;
(
  input  row_t r0,
  input  row_t r1,
  input  row_t r2,
  output row_t a,
  output row_t b
);
  logic s3, c3, s4, c4, s5, c5;

  wt_fa u_fa_c3 (.a(r0[3]), .b(r1[3]), .ci(r2[3]), .s(s3), .co(c3));
  wt_ha u_ha_c4 (.a(r0[4]), .b(r1[4]), .s(s4), .co(c4));
  wt_fa u_fa_c5 (.a(r0[5]), .b(r1[5]), .ci(r2[5]), .s(s5), .co(c5));

  always_comb begin
    a = '0;
    b = '0;
    a[0] = r0[0];
    a[1] = r0[1];
    b[1] = r1[1];
    a[2] = r0[2];
    a[3] = s3;
    a[4] = s4;
    b[4] = c3;
    a[5] = s5;
    b[5] = c4;
    a[6] = r0[6];
    b[6] = c5;
  end

  always_comb begin
    // R1: two-row output carries the same value as the three-row input
    p_stage2_value_r1: assert (SUM_W'(a) + SUM_W'(b) ==
                               SUM_W'(r0) + SUM_W'(r1) + SUM_W'(r2))
      else $error("stage2 rows lost weight");
  end
endmodule

// File: rtl/wt_rca.sv
module wt_rca #(
  parameter int W = 7
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    wt_fa u_fa (.a(a[k]), .b(b[k]), .ci(c[k]), .s(s[k]), .co(c[k+1]));
  end

  assign cout = c[W];
endmodule

// File: rtl/wallace_mul4.sv
module wallace_mul4
  import wt_pkg::*;
(
  input  logic [OP_W-1:0]   x,
  input  logic [OP_W-1:0]   y,
  output logic [PROD_W-1:0] z
);
  localparam int TAIL_W = PROD_W - 1;

  pp_mat_t           pp;
  row_t              r0, r1, r2;
  row_t              row_a, row_b;
  logic [TAIL_W-1:0] tail;
  logic              final_cout;

  wt_ppgen  u_pp (.x(x), .y(y), .pp(pp));
  wt_stage1 u_s1 (.pp(pp), .r0(r0), .r1(r1), .r2(r2));
  wt_stage2 u_s2 (.r0(r0), .r1(r1), .r2(r2), .a(row_a), .b(row_b));

  wt_rca #(.W(TAIL_W)) u_cpa (
    .a    (row_a[PROD_W-1:1]),
    .b    (row_b[PROD_W-1:1]),
    .s    (tail),
    .cout (final_cout)
  );

  assign z = {tail, row_a[0]};

  always_comb begin
    p_product_r1: assert (SUM_W'(z) == SUM_W'(x) * SUM_W'(y))
      else $error("product mismatch");
    p_rows_value_r1: assert (SUM_W'(row_a) + SUM_W'(row_b) == SUM_W'(x) * SUM_W'(y))
      else $error("final rows mismatch");
    p_lsb_direct_r2: assert (z[0] == (x[0] & y[0]))
      else $error("bit 0 mismatch");
    p_cout_zero_r3: assert (!final_cout)
      else $error("final adder carried out of bit 7");
  end
endmodule

// File: tb/tb_wallace_mul4.sv
module tb_wallace_mul4;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [3:0] x;
  logic [3:0] y;
  logic [7:0] z;
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] res [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  wallace_mul4 dut (.x(x), .y(y), .z(z));

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int a, int b);
    @(negedge clk);
    x = 4'(a);
    y = 4'(b);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 10000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    x = 4'd0;
    y = 4'd0;
    #1;
    chk("R4 start state zero", int'(z), 0);

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        drive(a, b);
        res[a*16+b] = z;
        chk("R1 full product", int'(z), a * b);
        chk("R2 bit0", int'(z[0]), (a & b) & 1);
        if (a == 0 || b == 0) chk("R4 zero operand", int'(z), 0);
        if (b == 1) begin
          chk("R5 low nibble", int'(z[3:0]), a);
          chk("R5 high nibble", int'(z[7:4]), 0);
        end
      end
    end

    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        chk("R7 swap", int'(res[a*16+b]), int'(res[b*16+a]));

    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 16; b++) begin
        drive(1 << k, b);
        chk("R6 shift", int'(z), b << k);
      end

    drive(15, 15);
    chk("R3 max product", int'(z), 225);
    chk("R3 top nibble", int'(z[7:4]), 14);

    @(negedge clk);
    x = 4'd9;
    y = 4'd13;
    #1;
    chk("R8 same step", int'(z), 117);
    x = 4'd7;
    #1;
    chk("R8 no clock edge", int'(z), 91);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule